// File: doc/BRIEF.md
# Conditional Move Predicate Evaluator

This block decides whether a conditional floating-point register move takes effect. It looks at one of three predicate families, picked by a two-bit source input. The first family tests a two-bit floating comparison code, taken from one of four fields of the floating status word. The second tests a four-bit integer flag nibble, either the 32-bit or the 64-bit set of an eight-bit condition register. The third tests the sign and zero state of a 64-bit signed register value. The answer is a single bit that says whether the move should be performed.

The instruction word supplies the condition number, the invert bit, the field selectors and the register specifier. The surrounding pipeline fetches the register value and performs the move. The decision logic is purely combinational. A parameter adds an output register, which is on by default. The block has no state machine. Its only state is that optional output flop, which resets to "no move".

Top module: `cmov_pred`

## Requirements
- R1: The `src` input selects the family: 0 selects floating, 1 selects integer, 2 selects register. The code 3 forces `take` to 0 whatever the other inputs are.
- R2: Floating family: when `instr[12:11]` is 0, the code is `fsr[11:10]`. When it is 1, 2 or 3, the code is `fsr[33:32]`, `fsr[35:34]` or `fsr[37:36]` respectively.
- R3: The floating code means 0 equal, 1 less, 2 greater, 3 unordered. The condition `instr[16:14]` works as follows:
  - 0: never true.
  - 1: true when the code is not 0.
  - 2: true when the code is 1 or 2.
  - 3: true when the code is 1 or 3.
  - 4: true when the code is 1.
  - 5: true when the code is 2 or 3.
  - 6: true when the code is 2.
  - 7: true when the code is 3.
- R4: In the floating and integer families, `instr[17]` inverts the result chosen by `instr[16:14]`. With that bit set, condition 0 is always true.
- R5: Integer family: the flag nibble is `icc[3:0]` when `instr[12]` is 0 and `icc[7:4]` when it is 1. Inside the nibble, bit 3 is negative (N), bit 2 is zero (Z), bit 1 is overflow (V) and bit 0 is carry (C).
- R6: The integer condition `instr[16:14]` works as follows:
  - 0: never true.
  - 1: Z.
  - 2: Z or (N xor V).
  - 3: N xor V.
  - 4: C or Z.
  - 5: C.
  - 6: N.
  - 7: V.
- R7: Register family: `rval` is a signed 64-bit value. The condition `instr[11:10]` works as follows:
  - 0: never true.
  - 1: true when the value equals zero.
  - 2: true when the value is less than or equal to zero.
  - 3: true when the value is negative.

  `instr[12]` inverts the result.
- R8: Register family: a specifier `instr[18:14]` of 0 makes the tested value zero, whatever `rval` carries.
- R9: With the default output register, `take` shows the decision for the inputs present at the previous rising clock edge. While `rst_n` is low, `take` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| src | input | 2 | Predicate family select |
| instr | input | 32 | Conditional move instruction word |
| fsr | input | FSR_W (64) | Floating status word holding the four comparison codes |
| icc | input | 8 | Integer condition register: 32-bit flags low, 64-bit flags high |
| rval | input | VAL_W (64) | Value of the register named by `instr[18:14]` |
| take | output | 1 | 1 when the move is to be performed |

## Verification
Two functions can meet in one cycle. In the first, the register specifier is 0 while `rval` carries a negative or non-zero value. The vectors pair such values with every register condition and both invert settings. The expected decision must follow the forced-zero value and not the port. In the second, the unused source code 3 is driven together with instruction and flag fields that would make a family true, including the inverted "always" condition. In that case `take` must still read 0 one cycle later. Both cases are judged by the scoreboard against a model written from the requirements.

// File: rtl/cmov_pkg.sv
package cmov_pkg;
    typedef enum logic [1:0] {
        SRC_FLT  = 2'd0,
        SRC_INT  = 2'd1,
        SRC_REG  = 2'd2,
        SRC_NONE = 2'd3
    } src_e;

    // instruction field positions
    localparam int COND_LSB   = 14;
    localparam int INV_BIT    = 17;
    localparam int FSEL_LSB   = 11;
    localparam int XFLAG_BIT  = 12;
    localparam int RCOND_LSB  = 10;
    localparam int RINV_BIT   = 12;
    localparam int RSPEC_LSB  = 14;
    localparam int RSPEC_W    = 5;

    // status word field positions
    localparam int FCC0_LSB   = 10;
    localparam int FCCX_BASE  = 30;
    localparam int FSR_MIN_W  = 38;
endpackage

// File: rtl/fcc_eval.sv
module fcc_eval
    import cmov_pkg::*;
#(
    parameter int FSR_W = 64
) (
    input  logic [2:0]       cond,
    input  logic             inv,
    input  logic [1:0]       fsel,
    input  logic [FSR_W-1:0] fsr,
    output logic             hit
);
    logic [1:0] code;
    logic       base;

    always_comb begin
        unique case (fsel)
            2'd0: code = fsr[FCC0_LSB +: 2];
            2'd1: code = fsr[FCCX_BASE + 2 +: 2];
            2'd2: code = fsr[FCCX_BASE + 4 +: 2];
            default: code = fsr[FCCX_BASE + 6 +: 2];
        endcase
    end

    always_comb begin
        unique case (cond)
            3'd0: base = 1'b0;
            3'd1: base = (code != 2'd0);
            3'd2: base = (code == 2'd1) || (code == 2'd2);
            3'd3: base = code[0];
            3'd4: base = (code == 2'd1);
            3'd5: base = code[1];
            3'd6: base = (code == 2'd2);
            default: base = (code == 2'd3);
        endcase
        hit = base ^ inv;
    end
endmodule

// File: rtl/icc_eval.sv
module icc_eval (
    input  logic [2:0] cond,
    input  logic       inv,
    input  logic       wide,
    input  logic [7:0] icc,
    output logic       hit
);
    logic [3:0] nib;
    logic       f_n, f_z, f_v, f_c;
    logic       base;

    always_comb begin
        nib = wide ? icc[7:4] : icc[3:0];
        f_n = nib[3];
        f_z = nib[2];
        f_v = nib[1];
        f_c = nib[0];
    end

    always_comb begin
        unique case (cond)
            3'd0: base = 1'b0;
            3'd1: base = f_z;
            3'd2: base = f_z | (f_n ^ f_v);
            3'd3: base = f_n ^ f_v;
            3'd4: base = f_c | f_z;
            3'd5: base = f_c;
            3'd6: base = f_n;
            default: base = f_v;
        endcase
        hit = base ^ inv;
    end
endmodule

// File: rtl/reg_eval.sv
module reg_eval
    import cmov_pkg::*;
#(
    parameter int VAL_W = 64
) (
    input  logic [1:0]         cond,
    input  logic               inv,
    input  logic [RSPEC_W-1:0] spec,
    input  logic [VAL_W-1:0]   rval,
    output logic               hit
);
    logic [VAL_W-1:0] val;
    logic             is_zero, is_neg, base;

    always_comb begin
        val     = (spec == '0) ? '0 : rval;
        is_zero = (val == '0);
        is_neg  = val[VAL_W-1];
        unique case (cond)
            2'd0: base = 1'b0;
            2'd1: base = is_zero;
            2'd2: base = is_zero | is_neg;
            default: base = is_neg;
        endcase
        hit = base ^ inv;
    end
endmodule

// File: rtl/cmov_pred.sv
module cmov_pred
    import cmov_pkg::*;
#(
    parameter int FSR_W   = 64,
    parameter int VAL_W   = 64,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       src,
    input  logic [31:0]      instr,
    input  logic [FSR_W-1:0] fsr,
    input  logic [7:0]       icc,
    input  logic [VAL_W-1:0] rval,
    output logic             take
);
    logic hit_flt, hit_int, hit_reg, decide;
    src_e sel;

    fcc_eval #(.FSR_W(FSR_W)) u_flt (
        .cond (instr[COND_LSB +: 3]),
        .inv  (instr[INV_BIT]),
        .fsel (instr[FSEL_LSB +: 2]),
        .fsr  (fsr),
        .hit  (hit_flt)
    );

    icc_eval u_int (
        .cond (instr[COND_LSB +: 3]),
        .inv  (instr[INV_BIT]),
        .wide (instr[XFLAG_BIT]),
        .icc  (icc),
        .hit  (hit_int)
    );

    reg_eval #(.VAL_W(VAL_W)) u_reg (
        .cond (instr[RCOND_LSB +: 2]),
        .inv  (instr[RINV_BIT]),
        .spec (instr[RSPEC_LSB +: RSPEC_W]),
        .rval (rval),
        .hit  (hit_reg)
    );

    always_comb begin
        sel = src_e'(src);
        unique case (sel)
            SRC_FLT: decide = hit_flt;
            SRC_INT: decide = hit_int;
            SRC_REG: decide = hit_reg;
            default: decide = 1'b0;
        endcase
    end

    logic unused_bits;
    assign unused_bits = ^{instr[31:19], instr[13], fsr};

    generate
        if (REG_OUT) begin : g_reg
            logic take_q;
            always_ff @(posedge clk) begin
                if (!rst_n) take_q <= 1'b0;
                else        take_q <= decide;
            end
            assign take = take_q;

            assert_none_src_R1: assert property (@(posedge clk) disable iff (!rst_n)
                (src == 2'd3) |=> !take);
            assert_flt_never_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (src == 2'd0 && instr[17:14] == 4'b0000) |=> !take);
            assert_inv_always_R4: assert property (@(posedge clk) disable iff (!rst_n)
                ((src == 2'd0 || src == 2'd1) && instr[17:14] == 4'b1000) |=> take);
            assert_neg_lt_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (src == 2'd2 && instr[18:14] != 5'd0 && rval[VAL_W-1]
                 && instr[12:10] == 3'b011) |=> take);
            assert_spec_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (src == 2'd2 && instr[18:14] == 5'd0 && instr[12:10] == 3'b001) |=> take);
        end else begin : g_comb
            assign take = decide;
        end
    endgenerate
endmodule

// File: tb/cmov_pred_test.sv
module cmov_pred_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  src = '0;
    logic [31:0] instr = '0;
    logic [63:0] fsr = '0;
    logic [7:0]  icc = '0;
    logic [63:0] rval = '0;
    logic        take;

    int n_run = 0;
    int n_fail = 0;
    bit exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cmov_pred uut (
        .clk(clk), .rst_n(rst_n), .src(src), .instr(instr),
        .fsr(fsr), .icc(icc), .rval(rval), .take(take)
    );

    function automatic bit m_flt(input int c, input logic [1:0] code);
        case (c)
            1: return code != 0;
            2: return code == 1 || code == 2;
            3: return code == 1 || code == 3;
            4: return code == 1;
            5: return code == 2 || code == 3;
            6: return code == 2;
            7: return code == 3;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit m_int(input int c, input logic [3:0] f);
        bit n, z, v, cy;
        n = f[3]; z = f[2]; v = f[1]; cy = f[0];
        case (c)
            1: return z;
            2: return z || (n != v);
            3: return n != v;
            4: return cy || z;
            5: return cy;
            6: return n;
            7: return v;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit m_reg(input int c, input longint v);
        case (c)
            1: return v == 0;
            2: return v <= 0;
            3: return v < 0;
            default: return 1'b0;
        endcase
    endfunction

    task automatic apply(input logic [1:0] s, input logic [31:0] ins, input logic [63:0] f,
                         input logic [7:0] ic, input logic [63:0] rv, input bit e, input string tg);
        @(negedge clk);
        src = s; instr = ins; fsr = f; icc = ic; rval = rv;
        exp_q.push_back(e);
        tag_q.push_back(tg);
    endtask

    // monitor: result appears one edge after the inputs
    always @(posedge clk) begin
        #1;
        if (rst_n && exp_q.size() > 0) begin
            bit e;
            string tg;
            e = exp_q.pop_front();
            tg = tag_q.pop_front();
            n_run++;
            if (take !== e) begin
                n_fail++;
                $display("FAIL %s: take=%b expected=%b", tg, take, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] v[6];
        // R9: reset state
        repeat (3) @(negedge clk);
        src = 2'd0; instr = 32'h0002_0000; // inverted never -> would be 1
        @(negedge clk);
        n_run++;
        if (take !== 1'b0) begin
            n_fail++;
            $display("FAIL R9 reset: take=%b expected=0", take);
        end
        rst_n = 1'b1;

        // R2/R3/R4 floating family
        for (int s = 0; s < 4; s++)
            for (int code = 0; code < 4; code++)
                for (int c = 0; c < 16; c++) begin
                    logic [63:0] f;
                    logic [31:0] ins;
                    logic [1:0] cd;
                    cd = code[1:0];
                    f = {16'hABCD, {4{~cd}}, 22'h15_5555, ~cd, 10'h2AA};
                    if (s == 0) f[11:10] = cd;
                    else f[30 + 2*s +: 2] = cd;
                    ins = 32'hFFF8_0000 | 32'(c) << 14 | 32'(s) << 11;
                    apply(2'd0, ins, f, 8'hFF, 64'h0, m_flt(c % 8, cd) ^ (c >= 8),
                          (c >= 8) ? "R4 flt invert" : "R2/R3 flt");
                end

        // R5/R6/R4 integer family
        for (int x = 0; x < 2; x++)
            for (int fl = 0; fl < 16; fl++)
                for (int c = 0; c < 16; c++) begin
                    logic [7:0] ic;
                    logic [3:0] fn;
                    fn = fl[3:0];
                    ic = (x == 1) ? {fn, ~fn} : {~fn, fn};
                    apply(2'd1, (32'(c) << 14) | (32'(x) << 12), 64'hFFFF_FFFF_FFFF_FFFF,
                          ic, 64'h0, m_int(c % 8, fn) ^ (c >= 8),
                          (c >= 8) ? "R4 int invert" : "R5/R6 int");
                end

        // R7/R8 register family
        v[0] = 64'h0; v[1] = 64'hFFFF_FFFF_FFFF_FFFF; v[2] = 64'h5;
        v[3] = 64'h8000_0000_0000_0000; v[4] = 64'h7FFF_FFFF_FFFF_FFFF;
        v[5] = 64'h0000_0001_0000_0000;
        for (int k = 0; k < 6; k++)
            for (int sp = 0; sp < 3; sp++)
                for (int rc = 0; rc < 8; rc++) begin
                    int spec;
                    longint tv;
                    spec = (sp == 0) ? 0 : (sp == 1 ? 5 : 20);
                    tv = (spec == 0) ? 64'sd0 : longint'(v[k]);
                    apply(2'd2, (32'(spec) << 14) | (32'(rc) << 10), 64'h0, 8'hFF, v[k],
                          m_reg(rc % 4, tv) ^ (rc >= 4),
                          (spec == 0) ? "R8 spec zero" : "R7 reg");
                end

        // R1: unused source forces 0
        apply(2'd3, 32'h0002_0000, 64'h0, 8'hFF, 64'h0, 1'b0, "R1 none inv-always");
        apply(2'd3, 32'h0000_1400, 64'h0, 8'hFF, 64'h0, 1'b0, "R1 none reg-zero");
        apply(2'd3, 32'h0000_4000, 64'hFFFF_FFFF_FFFF_FFFF, 8'h44, 64'h0, 1'b0, "R1 none flags");
        // R1: back to a live source in the next cycle
        apply(2'd1, 32'h0000_4000, 64'h0, 8'h04, 64'h0, 1'b1, "R1 int after none");

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule